// File: doc/BRIEF.md
# Operand Register Bank with Store Forwarding

This block holds the working registers of a small pipelined datapath. Eight registers of 32 bits each can be read on two operand ports at once, A and B, and one register can be written per cycle from the result bus. Each of the three ports has its own register select and its own enable. The two reads are combinational. A write takes effect on the rising clock edge.

Store instructions need the value being stored on the B operand bus. In the encoding used here, that value is named by the destination field. When the store-forward control is high, port B therefore reads the register addressed by the write select and ignores its own select. This lets the decoder route a store without rewiring the B select field.

The selects are 4 bits wide and only codes 0 to 7 name a register. A synchronous clear and a synchronous active-low reset both zero the whole bank.

Top module: `opd_regbank`

## Requirements
- R1: When `wr_en_i` is 1 at a rising edge and `wr_sel_i` is 0..7, register `wr_sel_i` takes `ry_data_i`. A read of that register from the next cycle on returns the new value.
- R2: When `wr_en_i` is 0 at an edge, no register changes, whatever `wr_sel_i` and `ry_data_i` carry.
- R3: A write with `wr_sel_i` in 8..15 changes no register.
- R4: With `rda_en_i` = 1 and `rda_sel_i` in 0..7, `rda_data_o` shows that register in the same cycle. A read of the register being written in the same cycle returns its value from before the edge.
- R5: With `rdb_en_i` = 1, `store_byp_i` = 0 and `rdb_sel_i` in 0..7, `rdb_data_o` shows register `rdb_sel_i` in the same cycle, with the same old-value rule as R4.
- R6: A read port whose enable is 0 drives zero.
- R7: An enabled read port whose effective select is in 8..15 drives zero.
- R8: With `store_byp_i` = 1 and `rdb_en_i` = 1, `rdb_data_o` shows the register addressed by `wr_sel_i` and ignores `rdb_sel_i`. If `wr_sel_i` is 8..15 the output is zero. Port A is unaffected, and `rdb_en_i` = 0 still gives zero.
- R9: When `clr_i` is 1 at an edge, every register becomes zero. Clear takes priority over a write in the same cycle.
- R10: When `rst_ni` is 0 at an edge, every register becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all registers |
| wr_en_i | input | 1 | Write port enable |
| wr_sel_i | input | 4 | Write register select (also the store-forward source) |
| ry_data_i | input | 32 | Result bus write data |
| rda_en_i | input | 1 | Port A read enable |
| rda_sel_i | input | 4 | Port A register select |
| rdb_en_i | input | 1 | Port B read enable |
| rdb_sel_i | input | 4 | Port B register select |
| store_byp_i | input | 1 | Store forward: port B reads the write-selected register |
| rda_data_o | output | 32 | Port A operand |
| rdb_data_o | output | 32 | Port B operand |

## Verification
The assertions check these properties on every cycle:
- Disabled and out-of-range ports drive zero.
- A write shows up on port A one cycle later, and a clear zeroes port A.
- Port A holds steady while nothing writes.
- With store forwarding on, port B matches port A whenever both point at the same register.

The bench's scenarios cover the rest:
- Writes to out-of-range selects leave every register intact.
- A clear beats a write in the same cycle.
- A same-cycle write is invisible to both reads.
- The mid-run reset, and the long mixed traffic, are compared against a behavioural model.

// File: rtl/opd_regbank_pkg.sv
package opd_regbank_pkg;

    localparam int DEF_DATA_W   = 32;
    localparam int DEF_NUM_REGS = 8;
    localparam int DEF_SEL_W    = 4;

    // Where port B takes its register address from
    typedef enum logic {
        PB_OWN_SEL   = 1'b0,
        PB_WRITE_SEL = 1'b1
    } pb_src_e;

endpackage

// File: rtl/opd_regbank_wdec.sv
module opd_regbank_wdec #(
    parameter int NUM_REGS = 8,
    parameter int SEL_W    = 4
) (
    input  logic                wr_en_i,
    input  logic [SEL_W-1:0]    wr_sel_i,
    output logic [NUM_REGS-1:0] wr_hit_o
);

    // One-hot write strobe; codes at or above NUM_REGS hit nothing
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign wr_hit_o[g] = wr_en_i && (wr_sel_i == SEL_W'(g));
    end

endmodule

// File: rtl/opd_regbank_store.sv
module opd_regbank_store #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       clr_i,
    input  logic [NUM_REGS-1:0]        wr_hit_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    output logic [NUM_REGS*DATA_W-1:0] bank_o
);

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t [NUM_REGS-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.regs = '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_hit_i[i]) begin
                    st_d.regs[i] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o = st_q.regs;

endmodule

// File: rtl/opd_regbank_rdport.sv
module opd_regbank_rdport #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SEL_W    = 4
) (
    input  logic [NUM_REGS*DATA_W-1:0] bank_i,
    input  logic                       en_i,
    input  logic [SEL_W-1:0]           sel_i,
    output logic [DATA_W-1:0]          data_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [SEL_W:0] LIMIT = (SEL_W + 1)'(NUM_REGS);

    logic             in_range;
    logic [IDX_W-1:0] idx;

    assign in_range = ({1'b0, sel_i} < LIMIT);
    assign idx      = sel_i[IDX_W-1:0];

    always_comb begin
        data_o = '0;
        if (en_i && in_range) begin
            data_o = bank_i[idx*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/opd_regbank.sv
module opd_regbank
    import opd_regbank_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int SEL_W    = DEF_SEL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [DATA_W-1:0] ry_data_i,
    input  logic              rda_en_i,
    input  logic [SEL_W-1:0]  rda_sel_i,
    input  logic              rdb_en_i,
    input  logic [SEL_W-1:0]  rdb_sel_i,
    input  logic              store_byp_i,
    output logic [DATA_W-1:0] rda_data_o,
    output logic [DATA_W-1:0] rdb_data_o
);

    logic [NUM_REGS-1:0]        wr_hit;
    logic [NUM_REGS*DATA_W-1:0] bank;
    pb_src_e                    pb_src;
    logic [SEL_W-1:0]           pb_sel;

    opd_regbank_wdec #(
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_wdec (
        .wr_en_i  (wr_en_i),
        .wr_sel_i (wr_sel_i),
        .wr_hit_o (wr_hit)
    );

    opd_regbank_store #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr_i),
        .wr_hit_i  (wr_hit),
        .wr_data_i (ry_data_i),
        .bank_o    (bank)
    );

    // Port B address source: own select, or the write select for stores
    assign pb_src = store_byp_i ? PB_WRITE_SEL : PB_OWN_SEL;

    always_comb begin
        unique case (pb_src)
            PB_WRITE_SEL: pb_sel = wr_sel_i;
            default:      pb_sel = rdb_sel_i;
        endcase
    end

    opd_regbank_rdport #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_rda (
        .bank_i (bank),
        .en_i   (rda_en_i),
        .sel_i  (rda_sel_i),
        .data_o (rda_data_o)
    );

    opd_regbank_rdport #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_rdb (
        .bank_i (bank),
        .en_i   (rdb_en_i),
        .sel_i  (pb_sel),
        .data_o (rdb_data_o)
    );

endmodule

// File: rtl/opd_regbank_chk.sv
module opd_regbank_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SEL_W    = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              clr_i,
    input logic              wr_en_i,
    input logic [SEL_W-1:0]  wr_sel_i,
    input logic [DATA_W-1:0] ry_data_i,
    input logic              rda_en_i,
    input logic [SEL_W-1:0]  rda_sel_i,
    input logic              rdb_en_i,
    input logic [SEL_W-1:0]  rdb_sel_i,
    input logic              store_byp_i,
    input logic [DATA_W-1:0] rda_data_o,
    input logic [DATA_W-1:0] rdb_data_o
);

    localparam logic [SEL_W:0] LIMIT = (SEL_W + 1)'(NUM_REGS);

    logic a_ok, b_ok, w_ok;
    assign a_ok = ({1'b0, rda_sel_i} < LIMIT);
    assign b_ok = ({1'b0, rdb_sel_i} < LIMIT);
    assign w_ok = ({1'b0, wr_sel_i} < LIMIT);

    // R6: disabled ports drive zero
    a_r6_rda_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rda_en_i |-> rda_data_o == '0);
    a_r6_rdb_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rdb_en_i |-> rdb_data_o == '0);

    // R7: out-of-range selects read zero
    a_r7_rda_oob: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rda_en_i && !a_ok |-> rda_data_o == '0);
    a_r7_rdb_oob: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdb_en_i && !store_byp_i && !b_ok |-> rdb_data_o == '0);

    // R1: written data visible on port A one cycle later
    a_r1_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(wr_en_i && !clr_i && w_ok) && rda_en_i
        && rda_sel_i == $past(wr_sel_i) |-> rda_data_o == $past(ry_data_i));

    // R2: with no write and no clear, a steady read stays steady
    a_r2_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && !$past(wr_en_i) && !$past(clr_i) && rda_en_i
        && $past(rda_en_i) && $stable(rda_sel_i) |-> $stable(rda_data_o));

    // R9: after a clear every register reads zero
    a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && $past(clr_i) && rda_en_i |-> rda_data_o == '0);

    // R8: store forwarding puts the write-selected register on port B
    a_r8_store_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        store_byp_i && rdb_en_i && rda_en_i && rda_sel_i == wr_sel_i
        |-> rdb_data_o == rda_data_o);

endmodule

bind opd_regbank opd_regbank_chk #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .SEL_W    (SEL_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .ry_data_i   (ry_data_i),
    .rda_en_i    (rda_en_i),
    .rda_sel_i   (rda_sel_i),
    .rdb_en_i    (rdb_en_i),
    .rdb_sel_i   (rdb_sel_i),
    .store_byp_i (store_byp_i),
    .rda_data_o  (rda_data_o),
    .rdb_data_o  (rdb_data_o)
);

// File: tb/sim_opd_regbank.sv
module sim_opd_regbank;

    localparam int PERIOD = 10;
    localparam int DW = 32;
    localparam int NR = 8;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n, clr, we, ae, be, byp;
    logic [SW-1:0] ws, as_, bs;
    logic [DW-1:0] wd;
    logic [DW-1:0] rda, rdb;

    always #(PERIOD / 2) clk = ~clk;

    opd_regbank #(.DATA_W(DW), .NUM_REGS(NR), .SEL_W(SW)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .clr_i       (clr),
        .wr_en_i     (we),
        .wr_sel_i    (ws),
        .ry_data_i   (wd),
        .rda_en_i    (ae),
        .rda_sel_i   (as_),
        .rdb_en_i    (be),
        .rdb_sel_i   (bs),
        .store_byp_i (byp),
        .rda_data_o  (rda),
        .rdb_data_o  (rdb)
    );

    logic [DW-1:0] model [NR];
    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    function automatic logic [DW-1:0] ref_rd(input bit en, input logic [SW-1:0] s);
        if (en && int'(s) < NR) return model[int'(s)];
        return '0;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input string tag, input bit rst, input bit c,
                        input bit w_en, input logic [SW-1:0] w_s, input logic [DW-1:0] w_d,
                        input bit a_en, input logic [SW-1:0] a_s,
                        input bit b_en, input logic [SW-1:0] b_s, input bit fwd);
        @(negedge clk);
        rst_n = !rst; clr = c; we = w_en; ws = w_s; wd = w_d;
        ae = a_en; as_ = a_s; be = b_en; bs = b_s; byp = fwd;
        #1;
        chk(tag, "port A", rda, ref_rd(a_en, a_s));
        chk(tag, "port B", rdb, ref_rd(b_en, fwd ? w_s : b_s));
        @(posedge clk);
        if (rst || c) begin
            for (int i = 0; i < NR; i++) model[i] = '0;
        end else if (w_en && int'(w_s) < NR) begin
            model[int'(w_s)] = w_d;
        end
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NR; i++)
            step(tag, 0, 0, 0, 4'(i), 32'hFFFF_FFFF, 1, 4'(i), 1, 4'(NR - 1 - i), 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; clr = 0; we = 0; ws = '0; wd = '0;
        ae = 0; as_ = '0; be = 0; bs = '0; byp = 0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < NR; i++) model[i] = '0;

        // R10: bank empty after reset
        read_all("R10");

        // R1: fill every register
        for (int i = 0; i < NR; i++)
            step("R1", 0, 0, 1, 4'(i), 32'hA000_0000 + 32'(i) * 32'h0111_0101,
                 1, 4'((i + NR - 1) % NR), 0, '0, 0);
        read_all("R1");

        // R4 / R5: same-cycle write is invisible to both reads
        step("R4", 0, 0, 1, 4'd3, 32'hDEAD_BEEF, 1, 4'd3, 1, 4'd3, 0);
        step("R5", 0, 0, 0, 4'd0, '0, 1, 4'd3, 1, 4'd3, 0);
        step("R5", 0, 0, 0, 4'd0, '0, 1, 4'd0, 1, 4'd7, 0);

        // R2: write enable low changes nothing
        step("R2", 0, 0, 0, 4'd5, 32'h1234_5678, 1, 4'd5, 0, '0, 0);
        step("R2", 0, 0, 0, 4'd5, 32'h1234_5678, 1, 4'd5, 1, 4'd5, 0);

        // R3: out-of-range writes ignored
        step("R3", 0, 0, 1, 4'd9,  32'h5555_5555, 0, '0, 0, '0, 0);
        step("R3", 0, 0, 1, 4'd15, 32'h6666_6666, 0, '0, 0, '0, 0);
        step("R3", 0, 0, 1, 4'd8,  32'h7777_7777, 0, '0, 0, '0, 0);
        read_all("R3");

        // R6: disabled ports drive zero
        step("R6", 0, 0, 0, 4'd0, '0, 0, 4'd1, 0, 4'd2, 0);
        step("R6", 0, 0, 0, 4'd0, '0, 0, 4'd4, 1, 4'd4, 0);

        // R7: out-of-range reads give zero
        step("R7", 0, 0, 0, 4'd0, '0, 1, 4'd8, 1, 4'd14, 0);
        step("R7", 0, 0, 0, 4'd0, '0, 1, 4'd15, 1, 4'd9, 0);

        // R8: store forwarding
        step("R8", 0, 0, 0, 4'd2, '0, 1, 4'd6, 1, 4'd6, 1);
        step("R8", 0, 0, 0, 4'd11, '0, 1, 4'd2, 1, 4'd2, 1);
        step("R8", 0, 0, 0, 4'd2, '0, 1, 4'd2, 0, 4'd2, 1);
        step("R8", 0, 0, 1, 4'd4, 32'hC0DE_0004, 1, 4'd4, 1, 4'd1, 1);
        step("R8", 0, 0, 0, 4'd4, '0, 1, 4'd1, 1, 4'd1, 1);

        // R9: clear beats a simultaneous write
        step("R9", 0, 1, 1, 4'd1, 32'hBAD0_0001, 1, 4'd1, 1, 4'd6, 0);
        read_all("R9");

        // Refill, then R10 mid-run reset
        for (int i = 0; i < NR; i++)
            step("R1", 0, 0, 1, 4'(i), $urandom, 1, 4'(i), 1, 4'(i), 0);
        step("R10", 1, 0, 1, 4'd2, 32'h0BAD_0BAD, 1, 4'd2, 1, 4'd3, 0);
        read_all("R10");

        // Mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            step("R4", 0, ($urandom % 40) == 0, ($urandom % 4) != 0,
                 4'($urandom), $urandom, ($urandom % 8) != 0, 4'($urandom),
                 ($urandom % 8) != 0, 4'($urandom), ($urandom % 4) == 0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule